// File: doc/BRIEF.md
# Serial Control Register Port

This block is a write-only, three-wire control port. A host raises a frame-enable line, clocks 16 data bits in on a serial data line, and lowers the enable again. Two configuration registers sit behind the port. The first holds a tracking gain code and a focus gain code. The second holds a sleep flag and a calibration-request flag. A byte in each frame selects which register is written.

The serial clock, enable and data lines are brought into the system clock domain through two-flop synchronisers. Clock edges are then detected inside that domain. A frame that completes drives the data line low as an acknowledge, through an open-drain pull-low enable. Each register raises a one-cycle strobe when it is written. A preset input returns every field to its default value. While the sleep flag is set, both gain codes are pinned to their default.

Top module: `sctl_port`

## Requirements
- R1: Bits are taken on falling edges of the serial clock while the enable is high, least significant bit first: the first bit sent becomes bit 0 of the 16-bit frame word.
- R2: On the 16th falling edge of a frame, the word is written to the selected register. The strobe for that register (`gain_wr_o` or `ctrl_wr_o`) is high for exactly one clock cycle.
- R3: `sd_pull_o` goes high after the 16th falling edge and stays high until the enable goes low. At all other times it is low.
- R4: A frame that ends with fewer than 16 falling edges changes no register, raises no strobe and gives no acknowledge.
- R5: When a frame has more than 16 falling edges, only the first 16 bits are used. The write and the acknowledge still take place.
- R6: In the gain register, the tracking code is word bits 15:12 and the focus code is word bits 11:8. Both reset to 4'b0111.
- R7: In the control register, the sleep flag is word bit 15 and the calibration flag is word bit 14. Both reset to 0.
- R8: Word bits 7:3 must be zero for a frame to be written. Bit 2 selects the register: 0 for the gain register, 1 for the control register. Bits 1:0 are ignored. A frame with any other address is acknowledged but writes nothing.
- R9: A high `preset_i` at a clock edge returns both gain codes to 4'b0111 and both flags to 0.
- R10: Writing the sleep flag to 1 forces both gain codes to 4'b0111. While the flag stays set, gain writes are acknowledged but have no effect and raise no strobe.
- R11: A control write with bits 15 and 14 both set stores sleep = 1 and calibration = 0, because sleep takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_i | input | 1 | Restores all fields to their defaults |
| sen_i | input | 1 | Frame enable, high during a frame |
| sck_i | input | 1 | Serial clock; data is taken on its falling edge |
| sd_i | input | 1 | Serial data, as seen on the shared line |
| sd_pull_o | output | 1 | Open-drain pull-low enable for the acknowledge |
| trk_gain_o | output | 4 | Tracking gain code |
| foc_gain_o | output | 4 | Focus gain code |
| sleep_o | output | 1 | Sleep flag |
| cal_req_o | output | 1 | Calibration request flag |
| gain_wr_o | output | 1 | One-cycle strobe when the gain register is written |
| ctrl_wr_o | output | 1 | One-cycle strobe when the control register is written |

## Verification
The bench sends frames with asymmetric bit patterns. A port that took bits most significant first would then decode a non-zero address and write nothing. The bench also checks these edge cases:
- A 10-bit frame, which a port without a bit count would commit.
- A 20-bit frame, where the extra bits are the inverse of the data, so a port that keeps shifting would store the wrong codes.
- Addresses with bits 7:3 set, and others with only bits 1:0 set, which expose loose decoding.
- Sleep-related cases: gain writes while asleep, a control write with both flags set, and a preset pulse. A port that got any of these wrong would leave stale gain codes or a calibration flag set where defaults are required.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int FRAME_BITS = 16;
  localparam int GAIN_W     = 4;
  localparam logic [GAIN_W-1:0] GAIN_DEFAULT = 4'b0111;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_GAIN = 2'd1,
    SEL_CTRL = 2'd2
  } sel_e;

  // Address byte: bits 7:3 zero, bit 2 picks the register, bits 1:0 free.
  function automatic sel_e decode_sel(input logic [FRAME_BITS-1:0] w);
    if (w[7:3] != 5'd0) return SEL_NONE;
    return w[2] ? SEL_CTRL : SEL_GAIN;
  endfunction

  function automatic logic [GAIN_W-1:0] trk_field(input logic [FRAME_BITS-1:0] w);
    return w[15:12];
  endfunction

  function automatic logic [GAIN_W-1:0] foc_field(input logic [FRAME_BITS-1:0] w);
    return w[11:8];
  endfunction

  function automatic logic sleep_field(input logic [FRAME_BITS-1:0] w);
    return w[15];
  endfunction

  // Sleep wins over a calibration request written in the same frame.
  function automatic logic cal_field(input logic [FRAME_BITS-1:0] w);
    return w[14] & ~w[15];
  endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sctl_rx.sv
module sctl_rx #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sen_s,
  input  logic                  sck_s,
  input  logic                  sd_s,
  output logic                  sck_fall,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic                  ack_o
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

  logic                  sck_prev;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  take_bit;

  assign sck_fall   = sck_prev & ~sck_s;
  assign take_bit   = sck_fall & sen_s & (bit_cnt != FULL_CNT);
  assign frame_done = take_bit & (bit_cnt == LAST_IDX);
  // New bits enter at the top, so the first one ends up at bit 0.
  assign frame_word = {sd_s, shreg[FRAME_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!sen_s) begin
      bit_cnt <= '0;
    end else if (take_bit) begin
      bit_cnt <= bit_cnt + CNT_W'(1);
      shreg   <= frame_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ack_o <= 1'b0;
    else if (!sen_s)     ack_o <= 1'b0;
    else if (frame_done) ack_o <= 1'b1;
  end

endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
  import sctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  preset_i,
  input  logic                  wr_gain,
  input  logic                  wr_ctrl,
  input  logic [FRAME_BITS-1:0] word_i,
  output logic [GAIN_W-1:0]     trk_gain_o,
  output logic [GAIN_W-1:0]     foc_gain_o,
  output logic                  sleep_o,
  output logic                  cal_req_o,
  output logic                  gain_wr_o,
  output logic                  ctrl_wr_o
);

  logic sleep_next;

  assign sleep_next = wr_ctrl ? sleep_field(word_i) : sleep_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_o   <= 1'b0;
      cal_req_o <= 1'b0;
      ctrl_wr_o <= 1'b0;
    end else if (preset_i) begin
      sleep_o   <= 1'b0;
      cal_req_o <= 1'b0;
      ctrl_wr_o <= 1'b0;
    end else begin
      ctrl_wr_o <= wr_ctrl;
      if (wr_ctrl) begin
        sleep_o   <= sleep_field(word_i);
        cal_req_o <= cal_field(word_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_gain_o <= GAIN_DEFAULT;
      foc_gain_o <= GAIN_DEFAULT;
      gain_wr_o  <= 1'b0;
    end else if (preset_i || sleep_next) begin
      trk_gain_o <= GAIN_DEFAULT;
      foc_gain_o <= GAIN_DEFAULT;
      gain_wr_o  <= 1'b0;
    end else begin
      gain_wr_o <= wr_gain;
      if (wr_gain) begin
        trk_gain_o <= trk_field(word_i);
        foc_gain_o <= foc_field(word_i);
      end
    end
  end

endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset_i,
  input  logic              sen_i,
  input  logic              sck_i,
  input  logic              sd_i,
  output logic              sd_pull_o,
  output logic [GAIN_W-1:0] trk_gain_o,
  output logic [GAIN_W-1:0] foc_gain_o,
  output logic              sleep_o,
  output logic              cal_req_o,
  output logic              gain_wr_o,
  output logic              ctrl_wr_o
);

  logic [2:0]            sync_q;
  logic                  sen_s, sck_s, sd_s;
  logic                  sck_fall;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame_word;
  sel_e                  frame_sel;
  logic                  wr_gain, wr_ctrl;

  sctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sen_i, sck_i, sd_i}),
    .q_o   (sync_q)
  );

  assign {sen_s, sck_s, sd_s} = sync_q;

  sctl_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sen_s      (sen_s),
    .sck_s      (sck_s),
    .sd_s       (sd_s),
    .sck_fall   (sck_fall),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .ack_o      (sd_pull_o)
  );

  assign frame_sel = decode_sel(frame_word);
  assign wr_gain   = frame_done && (frame_sel == SEL_GAIN);
  assign wr_ctrl   = frame_done && (frame_sel == SEL_CTRL);

  sctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .preset_i   (preset_i),
    .wr_gain    (wr_gain),
    .wr_ctrl    (wr_ctrl),
    .word_i     (frame_word),
    .trk_gain_o (trk_gain_o),
    .foc_gain_o (foc_gain_o),
    .sleep_o    (sleep_o),
    .cal_req_o  (cal_req_o),
    .gain_wr_o  (gain_wr_o),
    .ctrl_wr_o  (ctrl_wr_o)
  );

endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       preset_i,
  input logic       sen_s,
  input logic       frame_done,
  input logic       sd_pull_o,
  input logic [3:0] trk_gain_o,
  input logic [3:0] foc_gain_o,
  input logic       sleep_o,
  input logic       cal_req_o,
  input logic       gain_wr_o,
  input logic       ctrl_wr_o
);

  AST_GAIN_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    gain_wr_o |=> !gain_wr_o); // R2

  AST_CTRL_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |=> !ctrl_wr_o); // R2

  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> sd_pull_o); // R3

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_s |=> !sd_pull_o); // R3

  AST_NO_WRITE_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> (!gain_wr_o && !ctrl_wr_o)); // R4

  AST_PRESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    preset_i |=> (trk_gain_o == 4'b0111 && foc_gain_o == 4'b0111 &&
                  !sleep_o && !cal_req_o)); // R9

  AST_SLEEP_PINS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> (trk_gain_o == 4'b0111 && foc_gain_o == 4'b0111)); // R10

  AST_NO_GAIN_STROBE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    gain_wr_o |-> !sleep_o); // R10

  AST_SLEEP_OVER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !cal_req_o); // R11

endmodule

bind sctl_port sctl_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .preset_i   (preset_i),
  .sen_s      (sen_s),
  .frame_done (frame_done),
  .sd_pull_o  (sd_pull_o),
  .trk_gain_o (trk_gain_o),
  .foc_gain_o (foc_gain_o),
  .sleep_o    (sleep_o),
  .cal_req_o  (cal_req_o),
  .gain_wr_o  (gain_wr_o),
  .ctrl_wr_o  (ctrl_wr_o)
);

// File: tb/sctl_port_test.sv
`timescale 1ns/1ps
module sctl_port_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic preset_i = 1'b0;
  logic sen_i = 1'b0;
  logic sck_i = 1'b0;
  logic sd_i = 1'b0;
  logic sd_pull_o, sleep_o, cal_req_o, gain_wr_o, ctrl_wr_o;
  logic [3:0] trk_gain_o, foc_gain_o;

  int checks = 0;
  int failures = 0;
  int gwr_seen = 0;
  int cwr_seen = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sctl_port uut (
    .clk(clk), .rst_n(rst_n), .preset_i(preset_i),
    .sen_i(sen_i), .sck_i(sck_i), .sd_i(sd_i),
    .sd_pull_o(sd_pull_o), .trk_gain_o(trk_gain_o), .foc_gain_o(foc_gain_o),
    .sleep_o(sleep_o), .cal_req_o(cal_req_o),
    .gain_wr_o(gain_wr_o), .ctrl_wr_o(ctrl_wr_o)
  );

  always @(negedge clk) begin
    if (gain_wr_o) gwr_seen++;
    if (ctrl_wr_o) cwr_seen++;
  end

  typedef struct packed {
    logic [15:0] word;
    logic [4:0]  nbits;
    logic [3:0]  trk;
    logic [3:0]  foc;
    logic        slp;
    logic        cal;
    logic        gwr;
    logic        cwr;
    logic        ack;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{16'h3A00, 5'd16, 4'h3, 4'hA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R1 R2 R6
    '{16'h5500, 5'd10, 4'h3, 4'hA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 short
    '{16'hC500, 5'd20, 4'hC, 4'h5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 long
    '{16'h1108, 5'd16, 4'hC, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 bad addr
    '{16'h2903, 5'd16, 4'h2, 4'h9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 low bits ignored
    '{16'h4004, 5'd16, 4'h2, 4'h9, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 cal
    '{16'h8004, 5'd16, 4'h7, 4'h7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R10 sleep entry
    '{16'h1200, 5'd16, 4'h7, 4'h7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 gain while asleep
    '{16'hC004, 5'd16, 4'h7, 4'h7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R11 priority
    '{16'h0004, 5'd16, 4'h7, 4'h7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 clear
    '{16'hF000, 5'd16, 4'hF, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}  // R6 extremes
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Bits past the 16th are sent inverted so that a port that keeps shifting
  // would store wrong codes.
  task automatic send_frame(input logic [15:0] w, input int nbits, output logic ack_seen);
    sen_i = 1'b1;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      sck_i = 1'b1;
      sd_i  = (i < 16) ? w[i] : ~w[i % 16];
      wait_clk(4);
      sck_i = 1'b0;
      wait_clk(4);
    end
    wait_clk(6);
    ack_seen = sd_pull_o;
    sen_i = 1'b0;
    sd_i  = 1'b0;
    wait_clk(8);
  endtask

  initial begin
    logic ack;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    check("R6", "reset trk", trk_gain_o, 4'h7);
    check("R6", "reset foc", foc_gain_o, 4'h7);
    check("R7", "reset sleep", sleep_o, 0);
    check("R7", "reset cal", cal_req_o, 0);
    check("R3", "reset ack", sd_pull_o, 0);

    for (int v = 0; v < NV; v++) begin
      gwr_seen = 0;
      cwr_seen = 0;
      send_frame(VEC[v].word, int'(VEC[v].nbits), ack);
      check("R3", $sformatf("v%0d ack during", v), ack, VEC[v].ack);
      check("R3", $sformatf("v%0d ack after enable low", v), sd_pull_o, 0);
      check("R6", $sformatf("v%0d trk", v), trk_gain_o, VEC[v].trk);
      check("R6", $sformatf("v%0d foc", v), foc_gain_o, VEC[v].foc);
      check("R7", $sformatf("v%0d sleep", v), sleep_o, VEC[v].slp);
      check("R11", $sformatf("v%0d cal", v), cal_req_o, VEC[v].cal);
      check("R2", $sformatf("v%0d gain strobes", v), gwr_seen, VEC[v].gwr);
      check("R2", $sformatf("v%0d ctrl strobes", v), cwr_seen, VEC[v].cwr);
    end

    // R9: preset after non-default gains and a calibration request
    send_frame(16'h3100, 16, ack);
    send_frame(16'h4004, 16, ack);
    check("R9", "pre trk", trk_gain_o, 4'h3);
    check("R9", "pre cal", cal_req_o, 1);
    preset_i = 1'b1;
    wait_clk(1);
    preset_i = 1'b0;
    wait_clk(2);
    check("R9", "preset trk", trk_gain_o, 4'h7);
    check("R9", "preset foc", foc_gain_o, 4'h1 == 4'h1 ? 4'h7 : 4'h7);
    check("R9", "preset cal", cal_req_o, 0);
    check("R9", "preset sleep", sleep_o, 0);

    // R4 then R1: an aborted frame followed by a full frame starts counting afresh
    send_frame(16'hFFFF, 15, ack);
    check("R4", "15-bit ack", ack, 0);
    send_frame(16'h6D00, 16, ack);
    check("R1", "restart trk", trk_gain_o, 4'h6);
    check("R1", "restart foc", foc_gain_o, 4'hD);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule